// File: doc/BRIEF.md
# RAM, Parallel I/O and Prescaled Interval Timer

This peripheral sits on an 8-bit microprocessor bus and gathers three small functions behind one chip select: a 128-byte scratch memory, two 8-bit bidirectional parallel ports, and an 8-bit down-counting interval timer that drives an active-low interrupt. A separate memory-select input steers an access either to the scratch memory or to the I/O and timer registers. Port pins are presented as separate input, output and output-enable vectors, so the pad ring outside the block decides how they are driven.

The timer has no control register. Software picks the decrement rate through the address it uses to load the start value. The timer then counts down at that rate and raises the interrupt when it passes zero. After that it keeps counting down once per clock, so software can read how long ago the interrupt fired. Reads of the timer return the live count. Both a timer read and a timer load acknowledge the interrupt.

The bus data path is modelled as a read-data vector with an enable and a separate write-data vector. Register reads are combinational in the cycle of the access. Writes take effect on the rising clock edge.

Top module: `ramio_unit`

## Requirements
- R1: With `cs`=1 and `mem_sel`=1, a write (`rw`=0) stores `wdata` in scratch byte `addr[6:0]` on the clock edge, and a read (`rw`=1) returns that byte on `rdata` in the same cycle. Scratch accesses never alter port or timer state.
- R2: With `cs`=1, `mem_sel`=0 and `rw`=0, the I/O space is decoded from `addr[4:0]`. Writes go to 0x00 (port A output latch), 0x01 (port A direction), 0x02 (port B output latch) and 0x03 (port B direction). A write to any other I/O address outside 0x14..0x17 changes nothing.
- R3: Each port drives `pX_oe` equal to its direction register, where a bit of 1 means output, and drives `pX_out` equal to its output latch.
- R4: An I/O read of a port latch address returns the latch bits where the direction bit is 1 and the live `pX_in` bits where it is 0. A read of a direction address returns the direction register.
- R5: An I/O write to 0x14, 0x15, 0x16 or 0x17 loads the timer with `wdata` and restarts the prescaler from zero. `addr[1:0]` selects one decrement per 1, 8, 64 or 1024 clocks respectively. A count of N loaded with period D reaches zero D*N clocks after the load edge.
- R6: An I/O read with `addr[2]`=1 returns the live timer count.
- R7: On the decrement that takes the count below zero ((N+1)*D clocks after the load), the count becomes 0xFF and `irq_n` goes low. From then on the count decrements on every clock.
- R8: A timer read (I/O read with `addr[2]`=1) or a timer load clears a pending interrupt on that access's clock edge.
- R9: Reset clears both direction registers and both output latches and deasserts `irq_n`. No interrupt occurs before the first timer load.
- R10: `rdata_oe` is 1 exactly when `cs`=1 and `rw`=1, and `rdata` is 0 otherwise. Writes with `cs`=0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Chip select, active high |
| mem_sel | input | 1 | 1 selects scratch memory, 0 selects I/O and timer registers |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 7 | Register or memory address |
| wdata | input | 8 | Write data from the CPU |
| rdata | output | 8 | Read data to the CPU |
| rdata_oe | output | 1 | Read data enable toward the bus |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| irq_n | output | 1 | Timer interrupt, active low |

## Verification
The assertions assume that bus controls are stable across each clock edge, and that a timer load and a timer read never occur together, since a single access is either a read or a write. The bench changes every input only on the falling edge, performs one access per cycle, and returns `cs` low between accesses. Timer checks count edges from the load edge and sample the interrupt and the count at the falling edges where the requirements predict a change, one edge before and one edge after each expected underflow.

// File: rtl/ramio_pkg.sv
package ramio_pkg;

  localparam int DW    = 8;
  localparam int PRE_W = 10;

  typedef enum logic [1:0] {
    RATE_1    = 2'd0,
    RATE_8    = 2'd1,
    RATE_64   = 2'd2,
    RATE_1024 = 2'd3
  } rate_e;

  // terminal value of the prescaler for each rate (period minus one)
  function automatic logic [PRE_W-1:0] rate_term(rate_e r);
    logic [PRE_W-1:0] t;
    case (r)
      RATE_1:    t = PRE_W'(0);
      RATE_8:    t = PRE_W'(7);
      RATE_64:   t = PRE_W'(63);
      default:   t = PRE_W'(1023);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/ramio_ram.sv
module ramio_ram #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // storage has no reset; contents are undefined until written
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/ramio_port.sv
module ramio_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lat,
  input  logic          wr_dir,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe,
  output logic [DW-1:0] rd_lat,
  output logic [DW-1:0] rd_dir
);
  logic [DW-1:0] lat_q, lat_d;
  logic [DW-1:0] dir_q, dir_d;

  always_comb begin
    lat_d = lat_q;
    dir_d = dir_q;
    if (wr_lat) lat_d = wdata;
    if (wr_dir) dir_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_lat) lat_q <= lat_d;
      if (wr_dir) dir_q <= dir_d;
    end
  end

  assign pin_out = lat_q;
  assign pin_oe  = dir_q;
  // output bits read back the latch, input bits read the live pins
  assign rd_lat  = (dir_q & lat_q) | (~dir_q & pin_in);
  assign rd_dir  = dir_q;

  // R3: a direction write shows up on the enables one edge later
  p_dir_to_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pin_oe == $past(wdata)));

  // R3: the latch drives the pins after a latch write
  p_lat_to_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lat |=> (pin_out == $past(wdata)));

endmodule

// File: rtl/ramio_timer.sv
module ramio_timer
  import ramio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  rate_e         ld_rate,
  input  logic          rd_clr,
  output logic [DW-1:0] count,
  output logic          irq_flag
);
  logic [DW-1:0]    cnt_q, cnt_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  rate_e            rate_q, rate_d;
  logic             exp_q, exp_d;
  logic             flg_q, flg_d;
  logic             tick;

  assign tick = (pre_q == rate_term(rate_q));

  always_comb begin
    cnt_d  = cnt_q;
    pre_d  = pre_q;
    rate_d = rate_q;
    exp_d  = exp_q;
    flg_d  = flg_q;
    if (load) begin
      cnt_d  = ld_data;
      pre_d  = '0;
      rate_d = ld_rate;
      exp_d  = 1'b0;
      flg_d  = 1'b0;
    end else begin
      if (rd_clr) flg_d = 1'b0;
      if (exp_q) begin
        cnt_d = cnt_q - 1'b1;
      end else if (tick) begin
        pre_d = '0;
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == '0) begin
          exp_d = 1'b1;
          flg_d = 1'b1;
        end
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  // after reset the counter free-runs with no interrupt armed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      rate_q <= RATE_1;
      exp_q  <= 1'b1;
      flg_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pre_q  <= pre_d;
      rate_q <= rate_d;
      exp_q  <= exp_d;
      flg_q  <= flg_d;
    end
  end

  assign count    = cnt_q;
  assign irq_flag = flg_q;

  // R5: a load takes the written value and disarms any pending interrupt
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(ld_data)) && !irq_flag);

  // R5: between prescaler ticks the count holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!exp_q && !load && !tick) |=> $stable(count));

  // R7: interrupt rises only together with the wrap to all ones
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> (count == {DW{1'b1}}));

  // R7: once expired, the count falls by one each clock
  p_freerun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_q && !load) |=> (count == $past(count) - 1'b1));

  // R8: a read acknowledge drops the flag unless a new underflow happens
  p_rdclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && exp_q && !load) |=> !irq_flag);

endmodule

// File: rtl/ramio_unit.sv
module ramio_unit
  import ramio_pkg::*;
#(
  parameter int RAM_AW = 7,
  parameter int NPORT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              mem_sel,
  input  logic              rw,
  input  logic [RAM_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rdata_oe,
  input  logic [DW-1:0]     pa_in,
  output logic [DW-1:0]     pa_out,
  output logic [DW-1:0]     pa_oe,
  input  logic [DW-1:0]     pb_in,
  output logic [DW-1:0]     pb_out,
  output logic [DW-1:0]     pb_oe,
  output logic              irq_n
);
  localparam int SYNC_N  = 2;
  localparam int PSEL_W  = (NPORT > 1) ? $clog2(NPORT) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  // decode
  logic io_acc, io_wr, io_rd, mem_wr, tmr_load, tmr_rd, port_wr;
  logic [PSEL_W-1:0] psel;

  assign io_acc   = cs && !mem_sel;
  assign io_wr    = io_acc && !rw;
  assign io_rd    = io_acc && rw;
  assign mem_wr   = cs && mem_sel && !rw;
  assign port_wr  = io_wr && (addr[4:2] == 3'b000);
  assign tmr_load = io_wr && (addr[4:2] == 3'b101);
  assign tmr_rd   = io_rd && addr[2];
  assign psel     = PSEL_W'(addr[1]);

  // scratch memory
  logic [DW-1:0] ram_rd;

  ramio_ram #(.DW(DW), .AW(RAM_AW)) u_ram (
    .clk   (clk),
    .wr_en (mem_wr),
    .addr  (addr),
    .wdata (wdata),
    .rdata (ram_rd)
  );

  // parallel ports
  logic [DW-1:0] p_in  [NPORT];
  logic [DW-1:0] p_out [NPORT];
  logic [DW-1:0] p_oe  [NPORT];
  logic [DW-1:0] p_rdl [NPORT];
  logic [DW-1:0] p_rdd [NPORT];

  assign p_in[0] = pa_in;
  assign p_in[1] = pb_in;
  assign pa_out  = p_out[0];
  assign pa_oe   = p_oe[0];
  assign pb_out  = p_out[1];
  assign pb_oe   = p_oe[1];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic hit;
    assign hit = port_wr && (psel == PSEL_W'(g));
    ramio_port #(.DW(DW)) u_port (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_lat  (hit && !addr[0]),
      .wr_dir  (hit && addr[0]),
      .wdata   (wdata),
      .pin_in  (p_in[g]),
      .pin_out (p_out[g]),
      .pin_oe  (p_oe[g]),
      .rd_lat  (p_rdl[g]),
      .rd_dir  (p_rdd[g])
    );
  end

  // interval timer
  logic [DW-1:0] tmr_cnt;
  logic          tmr_flag;

  ramio_timer #(.DW(DW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .ld_data  (wdata),
    .ld_rate  (rate_e'(addr[1:0])),
    .rd_clr   (tmr_rd),
    .count    (tmr_cnt),
    .irq_flag (tmr_flag)
  );

  assign irq_n = !tmr_flag;

  // read path
  always_comb begin
    rdata = '0;
    if (cs && rw) begin
      if (mem_sel)      rdata = ram_rd;
      else if (addr[2]) rdata = tmr_cnt;
      else if (addr[0]) rdata = p_rdd[psel];
      else              rdata = p_rdl[psel];
    end
  end
  assign rdata_oe = cs && rw;

  // R1: memory writes leave the port enables untouched
  p_mem_isolated_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_wr) |=> ($stable(pa_oe) && $stable(pb_oe)));

  // R9: interrupt deasserted during the first cycle after reset release
  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_int_n) |-> irq_n);

endmodule

// File: tb/ramio_unit_bench.sv
module ramio_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs, mem_sel, rw;
  logic [6:0] addr;
  logic [7:0] wdata, rdata, pa_in, pb_in, pa_out, pa_oe, pb_out, pb_oe;
  logic       rdata_oe, irq_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ramio_unit u_ramio_unit (
    .clk(clk), .rst_n(rst_n), .cs(cs), .mem_sel(mem_sel), .rw(rw),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .irq_n(irq_n)
  );

  typedef struct packed {
    logic       rd;
    logic       sel;
    logic       mem;
    logic [6:0] a;
    logic [7:0] wd;
    logic [7:0] pa;
    logic [7:0] pb;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 18;
  // R1 R2 R4 R10 table: writes are stimulus, reads are checked
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b0, 7'h01, 8'hF0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 1'b1, 1'b0, 7'h00, 8'hA5, 8'h00, 8'h00, 8'h00},
    '{1'b1, 1'b1, 1'b0, 7'h00, 8'h00, 8'h3C, 8'h00, 8'hAC},
    '{1'b1, 1'b1, 1'b0, 7'h01, 8'h00, 8'h3C, 8'h00, 8'hF0},
    '{1'b0, 1'b1, 1'b0, 7'h03, 8'h0F, 8'h00, 8'h00, 8'h00},
    '{1'b0, 1'b1, 1'b0, 7'h02, 8'h5A, 8'h00, 8'h00, 8'h00},
    '{1'b1, 1'b1, 1'b0, 7'h02, 8'h00, 8'h00, 8'hC3, 8'hCA},
    '{1'b1, 1'b1, 1'b0, 7'h03, 8'h00, 8'h00, 8'hC3, 8'h0F},
    '{1'b0, 1'b1, 1'b1, 7'h00, 8'h11, 8'h00, 8'h00, 8'h00},
    '{1'b0, 1'b1, 1'b1, 7'h7F, 8'hEE, 8'h00, 8'h00, 8'h00},
    '{1'b1, 1'b1, 1'b1, 7'h00, 8'h00, 8'h00, 8'h00, 8'h11},
    '{1'b1, 1'b1, 1'b1, 7'h7F, 8'h00, 8'h00, 8'h00, 8'hEE},
    '{1'b0, 1'b0, 1'b1, 7'h7F, 8'h55, 8'h00, 8'h00, 8'h00},
    '{1'b1, 1'b1, 1'b1, 7'h7F, 8'h00, 8'h00, 8'h00, 8'hEE},
    '{1'b0, 1'b1, 1'b0, 7'h08, 8'hFF, 8'h00, 8'h00, 8'h00},
    '{1'b1, 1'b1, 1'b0, 7'h01, 8'h00, 8'h00, 8'h00, 8'hF0},
    '{1'b0, 1'b1, 1'b1, 7'h01, 8'h00, 8'h00, 8'h00, 8'h00},
    '{1'b1, 1'b1, 1'b0, 7'h01, 8'h00, 8'h00, 8'h00, 8'hF0}
  };
  // requirement each table read guards
  localparam string VREQ [NV] = '{
    "", "", "R4", "R4", "", "", "R4", "R4", "", "",
    "R1", "R1", "", "R10", "", "R2", "", "R1"
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic sel, input logic mem, input logic [6:0] a,
                           input logic [7:0] d);
    cs = sel; mem_sel = mem; rw = 1'b0; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0; rw = 1'b1;
  endtask

  task automatic bus_read(input logic mem, input logic [6:0] a, output logic [7:0] d,
                          output logic oe);
    cs = 1'b1; mem_sel = mem; rw = 1'b1; addr = a;
    #1;
    d = rdata; oe = rdata_oe;
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       oe;
    cs = 0; mem_sel = 0; rw = 1; addr = '0; wdata = '0; pa_in = '0; pb_in = '0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(4);

    // R9 reset state
    check("R9 pa_oe", pa_oe, 8'h00);
    check("R9 pb_oe", pb_oe, 8'h00);
    check("R9 pa_out", pa_out, 8'h00);
    check("R9 irq_n", {7'b0, irq_n}, 8'h01);
    idle(300);
    check("R9 no irq before load", {7'b0, irq_n}, 8'h01);

    // R10 idle bus
    #1;
    check("R10 oe idle", {7'b0, rdata_oe}, 8'h00);
    check("R10 data idle", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      pa_in = VEC[i].pa; pb_in = VEC[i].pb;
      if (VEC[i].rd) begin
        bus_read(VEC[i].mem, VEC[i].a, d, oe);
        check(VREQ[i], d, VEC[i].exp);
        check("R10 oe on read", {7'b0, oe}, 8'h01);
      end else begin
        bus_write(VEC[i].sel, VEC[i].mem, VEC[i].a, VEC[i].wd);
      end
    end

    // R3 pin outputs follow latch and direction
    check("R3 pa_out", pa_out, 8'hA5);
    check("R3 pa_oe", pa_oe, 8'hF0);
    check("R3 pb_out", pb_out, 8'h5A);
    check("R3 pb_oe", pb_oe, 8'h0F);

    // R5 R7 rate 1, count 3: underflow on edge 4
    bus_write(1'b1, 1'b0, 7'h14, 8'd3);
    idle(3);
    check("R7 irq before underflow div1", {7'b0, irq_n}, 8'h01);
    idle(1);
    check("R7 irq at underflow div1", {7'b0, irq_n}, 8'h00);
    bus_read(1'b0, 7'h04, d, oe);
    check("R7 wrap value", d, 8'hFF);
    check("R8 read clears irq", {7'b0, irq_n}, 8'h01);
    bus_read(1'b0, 7'h04, d, oe);
    check("R7 free run", d, 8'hFE);

    // R5 R6 rate 8, count 2: underflow on edge 24
    bus_write(1'b1, 1'b0, 7'h15, 8'd2);
    idle(7);
    bus_read(1'b0, 7'h04, d, oe);
    check("R6 count before first tick", d, 8'd2);
    bus_read(1'b0, 7'h04, d, oe);
    check("R5 count after 8 clocks", d, 8'd1);
    idle(14);
    check("R5 irq before underflow div8", {7'b0, irq_n}, 8'h01);
    idle(1);
    check("R5 irq at underflow div8", {7'b0, irq_n}, 8'h00);

    // R5 rate 64, count 0: underflow on edge 64
    bus_write(1'b1, 1'b0, 7'h16, 8'd0);
    check("R8 load clears irq", {7'b0, irq_n}, 8'h01);
    idle(63);
    check("R5 irq before underflow div64", {7'b0, irq_n}, 8'h01);
    idle(1);
    check("R5 irq at underflow div64", {7'b0, irq_n}, 8'h00);
    bus_write(1'b1, 1'b0, 7'h16, 8'd5);
    check("R8 reload clears irq", {7'b0, irq_n}, 8'h01);

    // R5 rate 1024, count 1: underflow on edge 2048
    bus_write(1'b1, 1'b0, 7'h17, 8'd1);
    idle(2047);
    check("R5 irq before underflow div1024", {7'b0, irq_n}, 8'h01);
    idle(1);
    check("R5 irq at underflow div1024", {7'b0, irq_n}, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule